// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of hardware timers. For each timer it turns a fire pulse into one of three kinds of interrupt event. The event can be a one-cycle pulse on a numbered interrupt-controller pin (edge signalling), a level held on that pin (level signalling), or a message request that carries a 32-bit address and a 32-bit data word.

Each timer owns a small configuration register that is loaded through a write strobe. The register holds an interrupt enable, the trigger type, a message enable and the destination pin. Messages are used only when the timer was built with message capability (parameter `MSG_CAP`) and its message enable is also set. In that case the timer is treated as having no pin. A destination pin that is not listed in the parameter `ALLOW_MASK` is stored as pin 0, and pin 0 means the timer is not routed.

Level signalling keeps a per-timer status bit. That bit holds the pin asserted until a clear request arrives. A configuration write that would leave the line stuck also drops the bit.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset, every status bit, message request, pin pulse, pin level and stored route reads 0.
- R2: A fire on a timer whose interrupt enable is 0 produces no pulse, no level and no request.
- R3: With trigger type 0 (edge), a fire on an enabled timer with a non-zero pin drives `pin_pulse_o[pin]` high for exactly the one cycle that follows the fire edge. The status bit is not set.
- R4: With trigger type 1 (level), a fire on an enabled timer with a non-zero pin sets `status_o[n]` and holds `pin_level_o[pin]` high from the cycle after the fire until the status bit clears.
- R5: A fire is dropped while the timer's status bit is set. When a fire and a clear arrive in the same cycle, the status bit ends at 0.
- R6: A timer whose effective pin is 0 delivers nothing on a pin.
- R7: Message delivery is chosen only when both `MSG_CAP[n]` and the message enable are 1. A timer without capability uses pin routing even when its message enable is set.
- R8: A message fire raises `msg_req_o[n]` one cycle later. It captures bits 63:32 of `msg_route_i` as the address and bits 31:0 as the data. The request, address and data hold until `msg_ack_i[n]` is seen with the request, and a fire while a request is pending is dropped.
- R9: A configuration write whose pin has a 0 bit in `ALLOW_MASK` stores route 0, readable on `route_o`.
- R10: When a configuration write lands while the status bit is set, the status bit clears and the pin level drops if the write does any of these: disables interrupts, selects edge, selects effective message delivery, or moves the effective pin. A write that keeps all four leaves the status bit set.
- R11: `clr_i[n]` clears a set status bit on the next edge. A clear with the bit already 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_i | input | NT | Per-timer fire pulse |
| cfg_we_i | input | NT | Per-timer configuration write strobe |
| cfg_ien_i | input | NT | Interrupt enable to write |
| cfg_lvl_i | input | NT | Trigger type to write (0 edge, 1 level) |
| cfg_msg_i | input | NT | Message enable to write |
| cfg_route_i | input | NT*PIN_W | Destination pin to write, PIN_W bits per timer |
| msg_route_i | input | NT*64 | Per-timer message route: address in 63:32, data in 31:0 |
| clr_i | input | NT | Per-timer status clear request |
| msg_ack_i | input | NT | Per-timer message request accepted |
| status_o | output | NT | Per-timer level status bits |
| pin_pulse_o | output | 2**PIN_W | One-cycle edge pulses, one bit per pin |
| pin_level_o | output | 2**PIN_W | Held level interrupts, one bit per pin |
| msg_req_o | output | NT | Per-timer message request |
| msg_addr_o | output | NT*32 | Per-timer captured message address |
| msg_data_o | output | NT*32 | Per-timer captured message data |
| route_o | output | NT*PIN_W | Per-timer stored route after the pin check |

## Verification
Some properties are checked on every cycle. A held pin level always has a status bit behind it. A pulse or a new status bit always follows a fire. A clear request always drops status. A pending message keeps its request, address and data until acceptance. A stored route is never a disallowed pin.

Other behaviour can only be shown by the bench's scenarios against its reference model: the exact pin a pulse lands on, the four configuration changes that force-clear status and the one that does not, a fire and a clear in the same cycle, the interplay of capability and message enable, and fires dropped while a message is pending.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int MSG_AW = 32;
  localparam int MSG_DW = 32;
  localparam int ROUTE_W = MSG_AW + MSG_DW;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/tmr_irq_cfg.sv
module tmr_irq_cfg
  import tmr_irq_pkg::*;
#(
  parameter int                      PIN_W      = 5,
  parameter logic [(1<<PIN_W)-1:0]   ALLOW_MASK = '0,
  parameter bit                      MSG_CAP    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             ien_i,
  input  logic             lvl_i,
  input  logic             msg_i,
  input  logic [PIN_W-1:0] route_i,
  output logic             ien_o,
  output trig_e            lvl_o,
  output logic             msg_eff_o,
  output logic [PIN_W-1:0] route_o,
  output logic [PIN_W-1:0] pin_o,
  output logic             kill_o
);
  logic             ien_q, msg_q;
  trig_e            lvl_q;
  logic [PIN_W-1:0] route_q, route_chk, new_pin;
  logic             new_meff;

  // disallowed pins collapse to "not routed"
  assign route_chk = ALLOW_MASK[route_i] ? route_i : '0;
  assign new_meff  = msg_i & MSG_CAP;
  assign new_pin   = new_meff ? '0 : route_chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q   <= 1'b0;
      lvl_q   <= TRIG_EDGE;
      msg_q   <= 1'b0;
      route_q <= '0;
    end else if (we_i) begin
      ien_q   <= ien_i;
      lvl_q   <= trig_e'(lvl_i);
      msg_q   <= msg_i;
      route_q <= route_chk;
    end
  end

  assign ien_o     = ien_q;
  assign lvl_o     = lvl_q;
  assign msg_eff_o = msg_q & MSG_CAP;
  assign route_o   = route_q;
  assign pin_o     = msg_eff_o ? '0 : route_q;

  // write that would strand a held level
  assign kill_o = we_i & (~ien_i | new_meff | (trig_e'(lvl_i) == TRIG_EDGE) |
                          (new_pin != pin_o));
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_pkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               ien_i,
  input  trig_e              lvl_i,
  input  logic               msg_eff_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic               clr_i,
  input  logic               kill_i,
  input  logic [ROUTE_W-1:0] route64_i,
  input  logic               ack_i,
  output logic               status_o,
  output logic               pulse_o,
  output logic [PIN_W-1:0]   pulse_pin_o,
  output logic               req_o,
  output logic [MSG_AW-1:0]  addr_o,
  output logic [MSG_DW-1:0]  data_o
);
  logic fire_ok, pin_path, pulse_d, set_lvl;

  assign fire_ok  = fire_i & ien_i & ~status_o;
  assign pin_path = fire_ok & ~msg_eff_i & (pin_i != '0);
  assign pulse_d  = pin_path & (lvl_i == TRIG_EDGE);
  assign set_lvl  = pin_path & (lvl_i == TRIG_LEVEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o    <= 1'b0;
      pulse_o     <= 1'b0;
      pulse_pin_o <= '0;
    end else begin
      status_o    <= status_o ? ~(clr_i | kill_i) : set_lvl;
      pulse_o     <= pulse_d;
      pulse_pin_o <= pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end else if (!req_o && fire_ok && msg_eff_i) begin
      req_o  <= 1'b1;
      addr_o <= route64_i[ROUTE_W-1:MSG_DW];
      data_o <= route64_i[MSG_DW-1:0];
    end
  end
endmodule

// File: rtl/tmr_irq_pinmux.sv
module tmr_irq_pinmux #(
  parameter int NT    = 3,
  parameter int PIN_W = 5,
  localparam int NPINS = 1 << PIN_W
) (
  input  logic [NT-1:0]       status_i,
  input  logic [NT*PIN_W-1:0] pin_i,
  input  logic [NT-1:0]       pulse_i,
  input  logic [NT*PIN_W-1:0] pulse_pin_i,
  output logic [NPINS-1:0]    level_o,
  output logic [NPINS-1:0]    pulse_o
);
  always_comb begin
    level_o = '0;
    pulse_o = '0;
    for (int t = 0; t < NT; t++) begin
      if (status_i[t]) level_o[pin_i[t*PIN_W +: PIN_W]] = 1'b1;
      if (pulse_i[t])  pulse_o[pulse_pin_i[t*PIN_W +: PIN_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int                    NT         = 3,
  parameter int                    PIN_W      = 5,
  parameter logic [NT-1:0]         MSG_CAP    = 3'b011,
  parameter logic [(1<<PIN_W)-1:0] ALLOW_MASK = 32'hFF00_0000,
  localparam int NPINS = 1 << PIN_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NT-1:0]         fire_i,
  input  logic [NT-1:0]         cfg_we_i,
  input  logic [NT-1:0]         cfg_ien_i,
  input  logic [NT-1:0]         cfg_lvl_i,
  input  logic [NT-1:0]         cfg_msg_i,
  input  logic [NT*PIN_W-1:0]   cfg_route_i,
  input  logic [NT*ROUTE_W-1:0] msg_route_i,
  input  logic [NT-1:0]         clr_i,
  input  logic [NT-1:0]         msg_ack_i,
  output logic [NT-1:0]         status_o,
  output logic [NPINS-1:0]      pin_pulse_o,
  output logic [NPINS-1:0]      pin_level_o,
  output logic [NT-1:0]         msg_req_o,
  output logic [NT*MSG_AW-1:0]  msg_addr_o,
  output logic [NT*MSG_DW-1:0]  msg_data_o,
  output logic [NT*PIN_W-1:0]   route_o
);
  logic [NT-1:0]       ien, meff, kill, pulse;
  trig_e               lvl [NT];
  logic [NT*PIN_W-1:0] pin, pulse_pin;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    tmr_irq_cfg #(
      .PIN_W(PIN_W), .ALLOW_MASK(ALLOW_MASK), .MSG_CAP(MSG_CAP[t])
    ) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cfg_we_i[t]),
      .ien_i     (cfg_ien_i[t]),
      .lvl_i     (cfg_lvl_i[t]),
      .msg_i     (cfg_msg_i[t]),
      .route_i   (cfg_route_i[t*PIN_W +: PIN_W]),
      .ien_o     (ien[t]),
      .lvl_o     (lvl[t]),
      .msg_eff_o (meff[t]),
      .route_o   (route_o[t*PIN_W +: PIN_W]),
      .pin_o     (pin[t*PIN_W +: PIN_W]),
      .kill_o    (kill[t])
    );

    tmr_irq_chan #(.PIN_W(PIN_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fire_i      (fire_i[t]),
      .ien_i       (ien[t]),
      .lvl_i       (lvl[t]),
      .msg_eff_i   (meff[t]),
      .pin_i       (pin[t*PIN_W +: PIN_W]),
      .clr_i       (clr_i[t]),
      .kill_i      (kill[t]),
      .route64_i   (msg_route_i[t*ROUTE_W +: ROUTE_W]),
      .ack_i       (msg_ack_i[t]),
      .status_o    (status_o[t]),
      .pulse_o     (pulse[t]),
      .pulse_pin_o (pulse_pin[t*PIN_W +: PIN_W]),
      .req_o       (msg_req_o[t]),
      .addr_o      (msg_addr_o[t*MSG_AW +: MSG_AW]),
      .data_o      (msg_data_o[t*MSG_DW +: MSG_DW])
    );
  end

  tmr_irq_pinmux #(.NT(NT), .PIN_W(PIN_W)) u_pinmux (
    .status_i    (status_o),
    .pin_i       (pin),
    .pulse_i     (pulse),
    .pulse_pin_i (pulse_pin),
    .level_o     (pin_level_o),
    .pulse_o     (pin_pulse_o)
  );
endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk
  import tmr_irq_pkg::*;
#(
  parameter int                    NT         = 3,
  parameter int                    PIN_W      = 5,
  parameter logic [NT-1:0]         MSG_CAP    = 3'b011,
  parameter logic [(1<<PIN_W)-1:0] ALLOW_MASK = 32'hFF00_0000,
  localparam int NPINS = 1 << PIN_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NT-1:0]        fire_i,
  input logic [NT-1:0]        clr_i,
  input logic [NT-1:0]        msg_ack_i,
  input logic [NT-1:0]        status_o,
  input logic [NPINS-1:0]     pin_pulse_o,
  input logic [NPINS-1:0]     pin_level_o,
  input logic [NT-1:0]        msg_req_o,
  input logic [NT*MSG_AW-1:0] msg_addr_o,
  input logic [NT*MSG_DW-1:0] msg_data_o,
  input logic [NT*PIN_W-1:0]  route_o
);
  // R4: a held level always has a status bit behind it
  a_r4_level_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pin_level_o) |-> (|status_o));

  // R3: a pulse only follows a fire
  a_r3_pulse_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pin_pulse_o) |-> $past(|fire_i));

  // R4: a status bit only rises after a fire on that timer
  a_r4_status_from_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~$past(status_o) & ~$past(fire_i)) == '0);

  for (genvar t = 0; t < NT; t++) begin : g_t
    // R11
    a_r11_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[t] && clr_i[t]) |=> !status_o[t]);

    // R8
    a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_req_o[t] && !msg_ack_i[t]) |=>
        (msg_req_o[t] && $stable(msg_addr_o[t*MSG_AW +: MSG_AW]) &&
         $stable(msg_data_o[t*MSG_DW +: MSG_DW])));

    // R9
    a_r9_route_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_o[t*PIN_W +: PIN_W] != '0) |-> ALLOW_MASK[route_o[t*PIN_W +: PIN_W]]);

    // R7
    if (!MSG_CAP[t]) begin : g_nocap
      a_r7_no_req_without_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !msg_req_o[t]);
    end
  end
endmodule

bind tmr_irq_router tmr_irq_router_chk #(
  .NT(NT), .PIN_W(PIN_W), .MSG_CAP(MSG_CAP), .ALLOW_MASK(ALLOW_MASK)
) u_chk (.*);

// File: tb/tmr_irq_router_test.sv
`timescale 1ns/1ps
module tmr_irq_router_test;
  localparam int NT = 3;
  localparam int PIN_W = 5;
  localparam int NPINS = 32;
  localparam logic [NT-1:0] CAP = 3'b011;
  localparam logic [31:0] ALLOW = 32'hFF00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NT-1:0] fire = '0, we = '0, ien = '0, lvl = '0, msg = '0, clr = '0, ack = '0;
  logic [NT*PIN_W-1:0] route = '0;
  logic [NT*64-1:0] r64 = '0;
  logic [NT-1:0] status, req;
  logic [NPINS-1:0] ppulse, plevel;
  logic [NT*32-1:0] addr, data;
  logic [NT*PIN_W-1:0] route_q;

  tmr_irq_router #(.NT(NT), .PIN_W(PIN_W), .MSG_CAP(CAP), .ALLOW_MASK(ALLOW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fire_i(fire), .cfg_we_i(we), .cfg_ien_i(ien),
    .cfg_lvl_i(lvl), .cfg_msg_i(msg), .cfg_route_i(route), .msg_route_i(r64),
    .clr_i(clr), .msg_ack_i(ack), .status_o(status), .pin_pulse_o(ppulse),
    .pin_level_o(plevel), .msg_req_o(req), .msg_addr_o(addr), .msg_data_o(data),
    .route_o(route_q));

  int tests = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  bit m_ien[NT], m_lvl[NT], m_msg[NT], m_st[NT], m_req[NT];
  int m_route[NT], m_ppin[NT];
  logic [31:0] m_addr[NT], m_data[NT];

  function automatic int m_pin(int t);
    return (m_msg[t] && CAP[t]) ? 0 : m_route[t];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        m_ien[t] = 0; m_lvl[t] = 0; m_msg[t] = 0; m_st[t] = 0; m_req[t] = 0;
        m_route[t] = 0; m_ppin[t] = 0; m_addr[t] = 0; m_data[t] = 0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        bit ok, me, set, kill, nme;
        int p, nr, np;
        me = m_msg[t] && CAP[t];
        p  = m_pin(t);
        ok = fire[t] && m_ien[t] && !m_st[t];
        m_ppin[t] = (ok && !me && p != 0 && !m_lvl[t]) ? p : 0;
        set = ok && !me && p != 0 && m_lvl[t];
        if (m_req[t] && ack[t]) m_req[t] = 0;
        else if (!m_req[t] && ok && me) begin
          m_req[t] = 1; m_addr[t] = r64[t*64+32 +: 32]; m_data[t] = r64[t*64 +: 32];
        end
        nr = int'(route[t*PIN_W +: PIN_W]);
        if (!ALLOW[nr]) nr = 0;
        nme = msg[t] && CAP[t];
        np = nme ? 0 : nr;
        kill = we[t] && (!ien[t] || nme || !lvl[t] || np != p);
        if (m_st[t]) m_st[t] = !(clr[t] || kill);
        else m_st[t] = set;
        if (we[t]) begin
          m_ien[t] = ien[t]; m_lvl[t] = lvl[t]; m_msg[t] = msg[t]; m_route[t] = nr;
        end
      end
    end
  end

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare();
    logic [NPINS-1:0] el, ep;
    el = '0; ep = '0;
    for (int t = 0; t < NT; t++) begin
      if (m_st[t]) el[m_pin(t)] = 1'b1;
      if (m_ppin[t] != 0) ep[m_ppin[t]] = 1'b1;
    end
    tests++;
    for (int t = 0; t < NT; t++) begin
      if (status[t] !== m_st[t] || req[t] !== m_req[t] ||
          route_q[t*PIN_W +: PIN_W] !== PIN_W'(m_route[t]) ||
          (m_req[t] && (addr[t*32 +: 32] !== m_addr[t] || data[t*32 +: 32] !== m_data[t]))) begin
        fails++;
        $display("FAIL %s model t%0d: actual st=%b req=%b rt=%0d expected st=%b req=%b rt=%0d",
                 tag, t, status[t], req[t], route_q[t*PIN_W +: PIN_W], m_st[t], m_req[t], m_route[t]);
        return;
      end
    end
    if (plevel !== el || ppulse !== ep) begin
      fails++;
      $display("FAIL %s model pins: actual lvl=%h pul=%h expected lvl=%h pul=%h",
               tag, plevel, ppulse, el, ep);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cfg(int t, bit e, bit l, bit m, int r);
    we[t] = 1; ien[t] = e; lvl[t] = l; msg[t] = m; route[t*PIN_W +: PIN_W] = PIN_W'(r);
    step();
    we[t] = 0;
  endtask

  task automatic fire1(int t);
    fire[t] = 1; step(); fire[t] = 0;
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    tag = "R1";
    chk("R1 status", status, 0); chk("R1 req", req, 0);
    chk("R1 level", plevel, 0); chk("R1 route", route_q, 0);
    rst_n = 1;
    step();

    // edge path
    tag = "R3";
    cfg(0, 1, 0, 0, 25);
    fire[0] = 1; @(posedge clk); @(negedge clk); fire[0] = 0; compare();
    chk("R3 pulse pin25", ppulse, 64'h1 << 25);
    chk("R3 no status", status, 0);
    step();
    chk("R3 pulse one cycle", ppulse, 0);

    tag = "R2";
    cfg(0, 0, 0, 0, 25);
    fire1(0);
    chk("R2 disabled no pulse", ppulse, 0);
    chk("R2 disabled no level", plevel, 0);

    // level path
    tag = "R4";
    cfg(1, 1, 1, 0, 26);
    fire1(1);
    chk("R4 status set", status, 3'b010);
    chk("R4 level pin26", plevel, 64'h1 << 26);
    step(); step();
    chk("R4 level held", plevel, 64'h1 << 26);

    tag = "R5";
    fire[1] = 1; clr[1] = 1; step(); fire[1] = 0; clr[1] = 0;
    chk("R5 fire with clear ends 0", status, 0);
    fire1(1);
    chk("R5 refire sets", status, 3'b010);
    fire1(1);
    chk("R5 fire while set no change", status, 3'b010);

    tag = "R11";
    clr[1] = 1; step(); clr[1] = 0;
    chk("R11 clear", status, 0);
    chk("R11 level gone", plevel, 0);
    clr[1] = 1; step(); clr[1] = 0;
    chk("R11 clear when clear", status, 0);

    // routing validity
    tag = "R9";
    cfg(2, 1, 0, 0, 3);
    chk("R9 disallowed route", route_q[2*PIN_W +: PIN_W], 0);
    tag = "R6";
    fire1(2);
    chk("R6 pin0 no pulse", ppulse, 0);
    chk("R6 pin0 no status", status, 0);

    // messages
    tag = "R8";
    r64[0 +: 64] = 64'hFEE0_1000_0000_0041;
    cfg(0, 1, 0, 1, 25);
    fire1(0);
    chk("R8 req", req, 3'b001);
    chk("R8 addr", addr[31:0], 32'hFEE0_1000);
    chk("R8 data", data[31:0], 32'h0000_0041);
    chk("R8 no pin pulse", ppulse, 0);
    r64[0 +: 64] = 64'h1111_2222_3333_4444;
    fire1(0);
    step();
    chk("R8 held addr", addr[31:0], 32'hFEE0_1000);
    chk("R8 held req", req, 3'b001);
    ack[0] = 1; step(); ack[0] = 0;
    chk("R8 ack drops", req, 0);
    fire1(0);
    chk("R8 new capture", addr[31:0], 32'h1111_2222);
    ack[0] = 1; step(); ack[0] = 0;

    tag = "R7";
    cfg(2, 1, 0, 1, 27);
    fire[2] = 1; @(posedge clk); @(negedge clk); fire[2] = 0; compare();
    chk("R7 no cap uses pin", ppulse, 64'h1 << 27);
    chk("R7 no cap no req", req, 0);

    // force-clear on config
    tag = "R10";
    fire1(1);
    chk("R10 armed", status, 3'b010);
    cfg(1, 1, 1, 0, 26);
    chk("R10 same cfg keeps", status, 3'b010);
    cfg(1, 1, 1, 0, 28);
    chk("R10 pin move clears", status, 0);
    chk("R10 pin move level", plevel, 0);
    fire1(1);
    cfg(1, 1, 0, 0, 28);
    chk("R10 edge clears", status, 0);
    cfg(1, 1, 1, 0, 28);
    fire1(1);
    cfg(1, 0, 1, 0, 28);
    chk("R10 disable clears", status, 0);
    cfg(1, 1, 1, 0, 28);
    fire1(1);
    chk("R10 rearmed", plevel, 64'h1 << 28);
    cfg(1, 1, 1, 1, 28);
    chk("R10 message clears", status, 0);
    step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule